// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block performs read lookups in a small two-way set-associative cache while driving only one tag comparator per clock. Every set keeps a single steering bit that names the way expected to hold the next line requested from that set. When a request is accepted, the set's steering bit picks one way. That way's tag is compared and its data is driven to the response mux in the first cycle. If that comparison fails, the same comparator checks the other way in the second cycle.

A correctly steered hit therefore answers one cycle after acceptance, and a hit in the other way answers after two cycles. A hit in the other way also flips the set's steering bit toward that way. When neither way matches, the block raises a refill request toward memory and waits, for any number of cycles, for the line to come back. It writes the returned line into the way that was not predicted, steers the set toward that way, and forwards the returned word to the requester in the same cycle. Three free-running counters expose how the responses split across the three outcomes.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and fill_req_o are 0, all three counters read 0, no line is valid and every steering bit is 0.
- R2: The set index is req_addr_i[IDX_W-1:0] and the tag is the remaining upper bits; lines in different sets never disturb each other's contents or steering.
- R3: When the steered way holds the line, rsp_valid_o is 1 with the stored word and rsp_miss_o 0 in the first cycle after the accepting edge.
- R4: When only the other way holds the line, the response comes in the second cycle after acceptance, and the set's steering bit then names that way, so an immediate repeat answers in one cycle.
- R5: When neither way holds the line, fill_req_o rises in the third cycle after acceptance with fill_addr_o equal to the request address, and both stay unchanged until fill_valid_i is seen.
- R6: In the cycle where fill_req_o and fill_valid_i are both 1, rsp_valid_o is 1 with rsp_data_o equal to fill_data_i and rsp_miss_o 1; the line is stored and the set's steering bit then names the way that received it.
- R7: A refill replaces the way the steering bit did not name, keeping the steered line. A way that was never filled never hits, even when the request tag equals its power-up contents.
- R8: req_ready_o is 0 from the cycle after an accepting edge up to and including the response cycle; req_valid_i is ignored while it is 0. Each accepted request gets exactly one response.
- R9: cnt_fast_o, cnt_slow_o and cnt_miss_o each rise by one for every one-cycle hit, two-cycle hit and miss respectively, and never otherwise.
- R10: fill_valid_i while no refill is outstanding produces no response and changes no stored line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request present |
| req_addr_i | input | ADDR_W | Word address of the lookup |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| rsp_valid_o | output | 1 | Response word valid this cycle |
| rsp_data_o | output | DATA_W | Response word |
| rsp_miss_o | output | 1 | Response came from a refill |
| fill_req_o | output | 1 | Refill outstanding toward memory |
| fill_addr_o | output | ADDR_W | Address of the line being refilled |
| fill_valid_i | input | 1 | Refill word delivered this cycle |
| fill_data_i | input | DATA_W | Refill word |
| cnt_fast_o | output | CNT_W | Count of one-cycle hits |
| cnt_slow_o | output | CNT_W | Count of two-cycle hits |
| cnt_miss_o | output | CNT_W | Count of misses |

## Verification
The assertions assume that fill_valid_i carries meaning only while fill_req_o is high and that the requester drops or keeps req_valid_i as it likes while the block is busy. The stimulus drives fill_valid_i during a refill only after checking fill_req_o. A stray fill pulse is sent only while the block is idle, and a request held high through a busy period is dropped in the response cycle so that it is never accepted.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2,
    ST_FILL   = 2'd3
  } lk_state_e;
endpackage

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_vld_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  // payload arrays carry no reset; valid bits gate them
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      dat_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_vld_o  = vld_q[rd_idx_i];
  assign rd_tag_o  = tag_q[rd_idx_i];
  assign rd_data_o = dat_q[rd_idx_i];
endmodule

// File: rtl/wpc_predictor.sv
module wpc_predictor #(
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             way_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_way_i
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] steer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       steer_q <= '0;
    else if (upd_en_i) steer_q[upd_idx_i] <= upd_way_i;
  end

  assign way_o = steer_q[rd_idx_i];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
  import wpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             probe_hit_i,
  input  logic             fill_valid_i,
  output lk_state_e        state_o,
  output logic             accept_o,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  output logic             rsp_miss_o,
  output logic             fill_req_o,
  output logic             fill_wr_o,
  output logic             steer_upd_o,
  output logic [CNT_W-1:0] cnt_fast_o,
  output logic [CNT_W-1:0] cnt_slow_o,
  output logic [CNT_W-1:0] cnt_miss_o
);
  lk_state_e  state_q, state_d;
  logic       fast_hit, slow_hit, miss;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign fast_hit    = (state_q == ST_FIRST)  &&  probe_hit_i;
  assign slow_hit    = (state_q == ST_SECOND) &&  probe_hit_i;
  assign miss        = (state_q == ST_SECOND) && !probe_hit_i;
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_wr_o   = fill_req_o && fill_valid_i;
  assign rsp_valid_o = fast_hit || slow_hit || fill_wr_o;
  assign rsp_miss_o  = fill_wr_o;
  assign steer_upd_o = slow_hit || fill_wr_o;
  assign state_o     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept_o)     state_d = ST_FIRST;
      ST_FIRST:  state_d = probe_hit_i ? ST_IDLE : ST_SECOND;
      ST_SECOND: state_d = probe_hit_i ? ST_IDLE : ST_FILL;
      ST_FILL:   if (fill_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_fast_o <= '0;
      cnt_slow_o <= '0;
      cnt_miss_o <= '0;
    end else begin
      state_q <= state_d;
      if (fast_hit) cnt_fast_o <= cnt_fast_o + 1'b1;
      if (slow_hit) cnt_slow_o <= cnt_slow_o + 1'b1;
      if (miss)     cnt_miss_o <= cnt_miss_o + 1'b1;
    end
  end

  a_r8_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  a_r8_single_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

  a_r5_fill_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> fill_req_o);
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_miss_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [CNT_W-1:0]  cnt_fast_o,
  output logic [CNT_W-1:0]  cnt_slow_o,
  output logic [CNT_W-1:0]  cnt_miss_o
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAYS  = 2;

  lk_state_e         state;
  logic              accept, probe_hit, fill_wr, steer_upd;
  logic              steer_way, probe_way, victim_way;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  set_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              w_vld [WAYS];
  logic [TAG_W-1:0]  w_tag [WAYS];
  logic [DATA_W-1:0] w_dat [WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (accept) addr_q <= req_addr_i;
  end

  assign set_idx    = addr_q[IDX_W-1:0];
  assign req_tag    = addr_q[ADDR_W-1:IDX_W];
  assign victim_way = ~steer_way;
  // steering bit picks the way before the compare; second cycle takes the other
  assign probe_way  = (state == ST_SECOND) ? ~steer_way : steer_way;
  // the single tag comparator of the block
  assign probe_hit  = w_vld[probe_way] && (w_tag[probe_way] == req_tag);
  assign rsp_data_o = fill_wr ? fill_data_i : w_dat[probe_way];
  assign fill_addr_o = addr_q;

  wpc_predictor #(.IDX_W(IDX_W)) u_pred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (set_idx),
    .way_o     (steer_way),
    .upd_en_i  (steer_upd),
    .upd_idx_i (set_idx),
    .upd_way_i (victim_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wpc_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (set_idx),
      .wr_en_i   (fill_wr && (victim_way == w[0])),
      .wr_idx_i  (set_idx),
      .wr_tag_i  (req_tag),
      .wr_data_i (fill_data_i),
      .rd_vld_o  (w_vld[w]),
      .rd_tag_o  (w_tag[w]),
      .rd_data_o (w_dat[w])
    );
  end

  wpc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .probe_hit_i  (probe_hit),
    .fill_valid_i (fill_valid_i),
    .state_o      (state),
    .accept_o     (accept),
    .req_ready_o  (req_ready_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_miss_o   (rsp_miss_o),
    .fill_req_o   (fill_req_o),
    .fill_wr_o    (fill_wr),
    .steer_upd_o  (steer_upd),
    .cnt_fast_o   (cnt_fast_o),
    .cnt_slow_o   (cnt_slow_o),
    .cnt_miss_o   (cnt_miss_o)
  );

  logic [CNT_W+1:0] cnt_total;
  assign cnt_total = CNT_W'(cnt_fast_o) + cnt_slow_o + cnt_miss_o;

  a_r4_retrain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SECOND && probe_hit) |=> (steer_way != $past(steer_way)));

  a_r6_fill_installs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_valid_i) |=> probe_hit);

  a_r5_fill_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> $stable(fill_addr_o));

  a_r9_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cnt_total - $past(cnt_total)) <= 1));
endmodule

// File: tb/wp_cache_lookup_tb.sv
`timescale 1ns/1ps
module wp_cache_lookup_tb;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int NVEC   = 18;

  // {addr[31:16], kind[15:8] (0 one-cycle hit, 1 two-cycle hit, 2 miss), fill delay[7:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0010, 8'd2, 8'd2}, {16'h0010, 8'd0, 8'd0}, {16'h0020, 8'd2, 8'd0},
    {16'h0020, 8'd0, 8'd0}, {16'h0010, 8'd1, 8'd0}, {16'h0010, 8'd0, 8'd0},
    {16'h0030, 8'd2, 8'd1}, {16'h0010, 8'd1, 8'd0}, {16'h0020, 8'd2, 8'd0},
    {16'h0013, 8'd2, 8'd0}, {16'h0020, 8'd0, 8'd0}, {16'h0013, 8'd0, 8'd0},
    {16'h0010, 8'd1, 8'd0}, {16'hFFF7, 8'd2, 8'd3}, {16'hFFF7, 8'd0, 8'd0},
    {16'h0007, 8'd2, 8'd0}, {16'h0007, 8'd0, 8'd0}, {16'hFFF7, 8'd1, 8'd0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              fill_valid = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              req_ready, rsp_valid, rsp_miss, fill_req;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] fill_addr;
  logic [CNT_W-1:0]  cnt_fast, cnt_slow, cnt_miss;

  int n_chk = 0, n_err = 0;
  int e_fast = 0, e_slow = 0, e_miss = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wp_cache_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_miss_o(rsp_miss),
    .fill_req_o(fill_req), .fill_addr_o(fill_addr),
    .fill_valid_i(fill_valid), .fill_data_i(fill_data),
    .cnt_fast_o(cnt_fast), .cnt_slow_o(cnt_slow), .cnt_miss_o(cnt_miss)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input int dly_in, input int kind);
    int dly = dly_in;
    int lat = 0;
    logic [DATA_W-1:0] d = '0;
    logic m = 1'b0;
    @(negedge clk);
    check("R8 ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (fill_req && !rsp_valid) begin
        check("R5 fill address", 32'(fill_addr), 32'(a));
        check("R5 refill raised in third cycle", 32'(lat >= 3), 32'd1);
        if (dly > 0) begin
          dly--;
          continue;
        end
        fill_valid = 1'b1;
        fill_data  = mem_word(a);
        #1;
      end
      if (rsp_valid) begin
        d = rsp_data;
        m = rsp_miss;
        break;
      end
      check("R8 busy while waiting", 32'(req_ready), 32'd0);
    end
    @(posedge clk);
    #1 fill_valid = 1'b0;
    case (kind)
      0: begin check("R3 one-cycle hit latency", lat, 1); e_fast++; end
      1: begin check("R4 two-cycle hit latency", lat, 2); e_slow++; end
      default: begin check("R5 R6 miss latency", lat, 3 + dly_in); e_miss++; end
    endcase
    check("R3 R6 response word", d, mem_word(a));
    check("R6 miss flag", 32'(m), 32'(kind == 2));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready in reset", 32'(req_ready), 32'd1);
    check("R1 no response in reset", 32'(rsp_valid), 32'd0);
    check("R1 no refill in reset", 32'(fill_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 counters zero", {cnt_fast, cnt_slow}, 32'd0);
    check("R1 miss counter zero", 32'(cnt_miss), 32'd0);

    // table walk: R2 sets, R3/R4 latency, R5/R6 refill, R7 victim and invalid way
    for (int v = 0; v < NVEC; v++) begin
      access(VEC[v][31:16], int'(VEC[v][7:0]), int'(VEC[v][15:8]));
    end

    // R8: request held through busy cycles is not taken
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'h0020;           // set 0 steered to way 1, line in way 0
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'h0050;            // would miss if taken
    check("R8 busy after accept", 32'(req_ready), 32'd0);
    check("R4 no answer in first cycle", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    check("R4 answer in second cycle", 32'(rsp_valid), 32'd1);
    check("R4 answer word", rsp_data, mem_word(16'h0020));
    req_valid = 1'b0;
    e_slow++;
    @(negedge clk);
    check("R8 held request ignored", 32'(rsp_valid | fill_req), 32'd0);
    check("R8 miss count untouched", 32'(cnt_miss), 32'(e_miss));

    // R10: stray refill pulse while idle
    fill_valid = 1'b1;
    fill_data  = 32'hDEAD_BEEF;
    #1 check("R10 stray fill gives no response", 32'(rsp_valid), 32'd0);
    @(posedge clk);
    #1 fill_valid = 1'b0;
    access(16'h0020, 0, 0);         // retrained line still intact
    access(16'h0010, 0, 1);

    // R9 counters
    @(negedge clk);
    check("R9 one-cycle hit count", 32'(cnt_fast), 32'(e_fast));
    check("R9 two-cycle hit count", 32'(cnt_slow), 32'(e_slow));
    check("R9 miss count", 32'(cnt_miss), 32'(e_miss));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule